// File: doc/BRIEF.md
# Receive idle timeout detector

This block sits beside a serial receiver's FIFO and flags that the host has left data unread while the line has gone quiet. It counts bit periods, using a baud-rate tick strobe, for as long as the FIFO holds at least one byte and neither a new byte arrives nor the host pops one. When the count reaches the programmed compare value plus one, a sticky timeout flag is raised. The interrupt output is that flag gated by an enable input.

Any arrival or pop restarts the count. An arrival leaves a raised flag in place, and only a pop, an empty FIFO or disabling the detector lowers it. A compare value of zero switches the detector off. The count stops at the threshold instead of wrapping.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, timeout_o and irq_o are 0.
- R2: With cmp_i equal to 0 the detector is disabled: timeout_o is 0 from the next cycle on and never sets.
- R3: With cmp_i = N (N > 0), the FIFO not empty and no activity, timeout_o rises after the clock edge that samples the (N+1)-th baud tick. It stays 0 after N ticks.
- R4: Clock cycles with baud_tick_i low do not advance the count.
- R5: A byte_rcvd_i pulse restarts the count, so a full N+1 ticks are needed again. It does not clear a timeout_o that is already set.
- R6: A fifo_rd_i pulse clears timeout_o on the next cycle and restarts the count.
- R7: While fifo_nempty_i is low the count is held at zero and timeout_o is 0 on the following cycle.
- R8: irq_o equals timeout_o AND irq_en_i, with no added delay.
- R9: Once set, timeout_o stays 1 under further ticks while the FIFO stays non-empty and no read occurs. The count saturates and does not wrap.
- R10: A baud tick in the same cycle as a byte_rcvd_i or fifo_rd_i pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle strobe per bit period |
| fifo_nempty_i | input | 1 | Receive FIFO holds at least one byte |
| byte_rcvd_i | input | 1 | Strobe: a byte was written into the FIFO |
| fifo_rd_i | input | 1 | Strobe: the host read a byte from the FIFO |
| cmp_i | input | CMP_W (9) | Compare value; 0 disables; threshold is cmp_i+1 |
| irq_en_i | input | 1 | Interrupt enable |
| timeout_o | output | 1 | Sticky timeout status flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions assume that cmp_i changes only while the FIFO is reported empty, so that the count never sits above a freshly lowered threshold. They also treat every strobe as a single-cycle event sampled at the clock edge. The random stimulus picks a new compare value between segments and holds fifo_nempty_i low for two cycles around each change. Inside a segment it toggles ticks, arrivals, reads and the empty state with weighted probabilities. Directed sequences cover the exact threshold edge, a tick that coincides with activity, and saturation.

// File: rtl/rto_pkg.sv
package rto_pkg;
  // threshold = compare value + 1, one bit wider than the compare field
  function automatic logic [9:0] rto_thr(input logic [8:0] cmp);
    return {1'b0, cmp} + 10'd1;
  endfunction
endpackage

// File: rtl/rto_counter.sv
module rto_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q < thr_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rto_flag.sv
module rto_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (clr_i)  flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout #(
  parameter int unsigned CMP_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             baud_tick_i,
  input  logic             fifo_nempty_i,
  input  logic             byte_rcvd_i,
  input  logic             fifo_rd_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             irq_en_i,
  output logic             timeout_o,
  output logic             irq_o
);
  localparam int unsigned CNT_W = CMP_W + 1;

  logic             enabled;
  logic             activity;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             flag_clr;
  logic             flag_set;
  logic             flag;

  assign enabled  = |cmp_i;
  assign activity = byte_rcvd_i | fifo_rd_i;
  assign thr      = {1'b0, cmp_i} + CNT_W'(1);

  assign cnt_clr  = !fifo_nempty_i || activity || !enabled;
  // a raised flag survives a new arrival; only a pop, empty or disable drop it
  assign flag_clr = !fifo_nempty_i || fifo_rd_i || !enabled;
  assign flag_set = baud_tick_i && !cnt_clr && (cnt >= thr - CNT_W'(1));

  rto_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .tick_i (baud_tick_i),
    .thr_i  (thr),
    .cnt_o  (cnt)
  );

  rto_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (flag_clr),
    .set_i  (flag_set),
    .flag_o (flag)
  );

  assign timeout_o = flag;
  assign irq_o     = flag & irq_en_i;
endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk #(
  parameter int unsigned CMP_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             baud_tick_i,
  input logic             fifo_nempty_i,
  input logic             byte_rcvd_i,
  input logic             fifo_rd_i,
  input logic [CMP_W-1:0] cmp_i,
  input logic             timeout_o,
  input logic [CMP_W:0]   cnt
);
  a_r2_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i == '0) |=> !timeout_o);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_i |=> (!timeout_o && cnt == '0));

  a_r7_empty_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_nempty_i |=> (!timeout_o && cnt == '0));

  a_r4_no_tick_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!baud_tick_i && fifo_nempty_i && !byte_rcvd_i && !fifo_rd_i && cmp_i != '0)
      |=> $stable(cnt));

  a_r3_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(baud_tick_i));

  a_r5_arrival_keeps_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_rcvd_i && !fifo_rd_i && fifo_nempty_i && cmp_i != '0)
      |=> (cnt == '0 && timeout_o == $past(timeout_o)));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && fifo_nempty_i && !fifo_rd_i && cmp_i != '0) |=> timeout_o);
endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.CMP_W(CMP_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .baud_tick_i   (baud_tick_i),
  .fifo_nempty_i (fifo_nempty_i),
  .byte_rcvd_i   (byte_rcvd_i),
  .fifo_rd_i     (fifo_rd_i),
  .cmp_i         (cmp_i),
  .timeout_o     (timeout_o),
  .cnt           (cnt)
);

// File: tb/test_rx_idle_timeout.sv
module test_rx_idle_timeout;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, nempty = 1'b0, rcvd = 1'b0, rd = 1'b0, ien = 1'b0;
  logic [8:0] cmp = '0;
  logic       tout, irq;

  int unsigned n_chk = 0, n_err = 0;
  int unsigned m_cnt = 0;
  bit          m_flag = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rx_idle_timeout i_rx_idle_timeout (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .fifo_nempty_i(nempty),
    .byte_rcvd_i(rcvd), .fifo_rd_i(rd), .cmp_i(cmp), .irq_en_i(ien),
    .timeout_o(tout), .irq_o(irq)
  );

  // bench model from the requirements
  function automatic bit next_flag(bit f, int unsigned c);
    int unsigned thr = cmp + 1;
    if (!nempty || rd || cmp == 0) return 1'b0;
    if (tick && !rcvd && c + 1 >= thr) return 1'b1;
    return f;
  endfunction

  function automatic int unsigned next_cnt(int unsigned c);
    int unsigned thr = cmp + 1;
    if (!nempty || rd || rcvd || cmp == 0) return 0;
    if (tick && c < thr) return c + 1;
    return c;
  endfunction

  task automatic check(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive after negedge, advance model at posedge, sample 1 ns later
  task automatic cyc(bit t, bit ne, bit rv, bit r, string req);
    @(negedge clk);
    tick = t; nempty = ne; rcvd = rv; rd = r;
    @(posedge clk);
    m_flag = next_flag(m_flag, m_cnt);
    m_cnt  = next_cnt(m_cnt);
    #1;
    check(req, tout, m_flag);
    check("R8", irq, m_flag & ien);
  endtask

  task automatic set_cmp(int unsigned v);
    cyc(0, 0, 0, 0, "R7");
    @(negedge clk); cmp = 9'(v);
    cyc(0, 0, 0, 0, "R7");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", tout, 1'b0);
    check("R1", irq, 1'b0);
    @(negedge clk); rst_n = 1'b1; ien = 1'b1;

    // R3/R4: cmp=3 needs 4 ticks, idle cycles between do not count
    set_cmp(3);
    cyc(0, 1, 1, 0, "R3");
    for (int i = 0; i < 3; i++) begin
      cyc(1, 1, 0, 0, "R3");
      cyc(0, 1, 0, 0, "R4");
      check("R3", tout, 1'b0);
    end
    cyc(1, 1, 0, 0, "R3");
    check("R3", tout, 1'b1);
    // R9: saturation, stays set
    for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, "R9");
    check("R9", tout, 1'b1);
    // R5: arrival keeps flag, restarts count
    cyc(1, 1, 1, 0, "R5");
    check("R5", tout, 1'b1);
    // R6: read clears
    cyc(0, 1, 0, 1, "R6");
    check("R6", tout, 1'b0);
    // R10: tick with activity not counted: 3 ticks + tick on read + 1 tick -> still low
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, "R10");
    cyc(1, 1, 0, 1, "R10");
    cyc(1, 1, 0, 0, "R10");
    check("R10", tout, 1'b0);
    // R7: empty clears a set flag
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, "R7");
    check("R7", tout, 1'b1);
    cyc(1, 0, 0, 0, "R7");
    check("R7", tout, 1'b0);
    // R8: mask
    cyc(0, 1, 1, 0, "R8");
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, "R8");
    @(negedge clk); ien = 1'b0; #1;
    check("R8", irq, 1'b0);
    @(negedge clk); ien = 1'b1; #1;
    check("R8", irq, 1'b1);
    // R2: disabled
    set_cmp(0);
    for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0, "R2");
    check("R2", tout, 1'b0);

    // random segments
    for (int s = 0; s < 40; s++) begin
      set_cmp($urandom_range(0, 6));
      @(negedge clk); ien = $urandom_range(0, 1);
      for (int i = 0; i < 200; i++)
        cyc(($urandom_range(0, 2) != 0), ($urandom_range(0, 19) != 0),
            ($urandom_range(0, 24) == 0), ($urandom_range(0, 29) == 0), "R3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule